// File: doc/BRIEF.md
# Dual-Rail Fetch-to-Memory Bridge

This block joins a fetch stage that speaks dual-rail, return-to-zero code to a program memory that speaks plain single-rail logic. Going out, every address bit arrives as a true/false rail pair. The memory receives the true rail of each pair as its address. A completion detector watches all pairs, and a state-holding hysteresis gate (a Muller C-element) turns that into a memory strobe. The strobe rises only once every pair carries a valid code. It falls only once every pair has gone back to the empty spacer. The memory enable pin is active low and is the inverse of that strobe.

Coming back, the 16-bit instruction word is built from two 8-bit memory outputs read side by side, with the high device giving bits 15:8. While the strobe is high, each word bit is spread onto a true rail and a false rail. While the strobe is low, every returned rail is held at zero. This gives the fetch stage the spacer phase that a four-phase return-to-zero handshake needs.

The C-element is modelled synchronously. Its state register samples the completion condition on each rising clock edge, so the strobe follows the address code one clock later. The gated instruction rails are combinational from the strobe.

Top module: `fetch_mem_bridge`

## Requirements
- R1: `memAddr` equals `addrTrue` at all times, independent of the strobe and of the false rails.
- R2: The strobe rises one clock after a cycle in which every address pair is valid, meaning exactly one of its two rails is high. While even one pair is still the spacer (both rails low), the strobe stays low.
- R3: Once high, the strobe stays high until a cycle in which every address pair is the spacer. It falls one clock after that cycle. A partial return to the spacer keeps it high.
- R4: A pair with both rails high is illegal. While any pair is illegal, the strobe keeps its value.
- R5: `memEnN` is the inverse of the strobe. After reset the strobe is low, so `memEnN` is 1.
- R6: While the strobe is high, `instrTrue` equals the word `{memHi, memLo}` (`memHi` in bits 15:8) and `instrFalse` equals its bitwise inverse. Both follow data changes in the same cycle.
- R7: While the strobe is low, every bit of `instrTrue` and `instrFalse` is 0, whatever the memory presents.
- R8: No instruction bit ever has its true and false rails high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the hysteresis gate state |
| rstN | input | 1 | Active-low reset, clears the strobe |
| addrTrue | input | ADDR_W (13) | True rails of the dual-rail address |
| addrFalse | input | ADDR_W (13) | False rails of the dual-rail address |
| memAddr | output | ADDR_W (13) | Single-rail address to the memory |
| memEnN | output | 1 | Active-low memory enable (inverse of the strobe) |
| memLo | input | BYTE_W (8) | Low memory device output, word bits 7:0 |
| memHi | input | BYTE_W (8) | High memory device output, word bits 15:8 |
| instrTrue | output | 2*BYTE_W (16) | True rails of the returned instruction |
| instrFalse | output | 2*BYTE_W (16) | False rails of the returned instruction |

## Verification
The hardest behaviour to reach from the ports is the hysteresis of the gate. The strobe's value must depend on its history when the address is only partly valid, partly spacer or illegal, and not only on the present address. The stimulus reaches these states in order. It drives an address that is valid except for one spacer pair, then completes it, then takes back only some pairs. It then injects an illegal both-high pair while the strobe is high, and again while it is low. Each of these steps checks that `memEnN` and the instruction rails keep their previous state.

// File: rtl/fetch_mem_bridge_pkg.sv
package fetch_mem_bridge_pkg;
  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic fire;     // memory strobe, high while the address is complete
    logic enableN;  // active-low memory enable
  } bridgeCtl_t;
endpackage

// File: rtl/hyst_gate.sv
// N-input Muller C-element with a state register: it goes high when every
// input of upVec is high, low when every input of dnVec is high, and holds otherwise.
module hyst_gate #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] upVec,
  input  logic [N-1:0] dnVec,
  output logic         q
);
  logic allUp, allDn;
  assign allUp = &upVec;
  assign allDn = &dnVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      q <= 1'b0;
    else if (allUp) q <= 1'b1;
    else if (allDn) q <= 1'b0;
  end

  // R3: a falling output must be caused by a full spacer one cycle earlier
  a_r3_fall_needs_spacer: assert property (@(posedge clk) disable iff (!rstN)
    $fell(q) |-> $past(allDn));
  // R2: a rising output must be caused by full completion one cycle earlier
  a_r2_rise_needs_complete: assert property (@(posedge clk) disable iff (!rstN)
    $rose(q) |-> $past(allUp));
endmodule

// File: rtl/bridge_ctrl.sv
// Completion detection over the dual-rail address, feeding the hysteresis gate.
module bridge_ctrl
  import fetch_mem_bridge_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrTrue,
  input  logic [ADDR_W-1:0] addrFalse,
  output bridgeCtl_t        ctl
);
  logic [ADDR_W-1:0] pairValid;
  logic [ADDR_W-1:0] pairSpacer;
  logic [ADDR_W-1:0] pairIllegal;
  logic              strobe;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_pair
    assign pairValid[i]   = addrTrue[i] ^ addrFalse[i];
    assign pairSpacer[i]  = ~(addrTrue[i] | addrFalse[i]);
    assign pairIllegal[i] = addrTrue[i] & addrFalse[i];
  end

  hyst_gate #(.N(ADDR_W)) u_gate (
    .clk  (clk),
    .rstN (rstN),
    .upVec(pairValid),
    .dnVec(pairSpacer),
    .q    (strobe)
  );

  assign ctl.fire    = strobe;
  assign ctl.enableN = ~strobe;

  // R2: a complete address raises the strobe on the next edge
  a_r2_complete_raises: assert property (@(posedge clk) disable iff (!rstN)
    (&pairValid) |=> strobe);
  // R3: a high strobe survives any cycle that is not a full spacer
  a_r3_partial_holds: assert property (@(posedge clk) disable iff (!rstN)
    (strobe && !(&pairSpacer)) |=> strobe);
  // R4: any illegal pair freezes the strobe
  a_r4_illegal_freezes: assert property (@(posedge clk) disable iff (!rstN)
    (|pairIllegal) |=> (strobe == $past(strobe)));
endmodule

// File: rtl/bridge_dpath.sv
// Address rail selection and gated single-to-dual-rail expansion of the word.
module bridge_dpath
  import fetch_mem_bridge_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  bridgeCtl_t          ctl,
  input  logic [ADDR_W-1:0]   addrTrue,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memEnN,
  input  logic [BYTE_W-1:0]   memLo,
  input  logic [BYTE_W-1:0]   memHi,
  output logic [2*BYTE_W-1:0] instrTrue,
  output logic [2*BYTE_W-1:0] instrFalse
);
  localparam int LANES  = 2;
  localparam int WORD_W = LANES * BYTE_W;

  logic [BYTE_W-1:0] lane [LANES];
  logic [WORD_W-1:0] word;

  assign lane[0] = memLo;
  assign lane[1] = memHi;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign word[l*BYTE_W +: BYTE_W] = lane[l];
  end

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    assign instrTrue[b]  = ctl.fire &  word[b];
    assign instrFalse[b] = ctl.fire & ~word[b];
  end

  assign memAddr = addrTrue;
  assign memEnN  = ctl.enableN;

  // R7: low strobe means the spacer on every returned rail
  a_r7_rtz_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.fire |-> ((instrTrue == '0) && (instrFalse == '0)));
  // R6: high strobe means each returned bit carries exactly one rail
  a_r6_complete_when_fired: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fire |-> ((instrTrue ^ instrFalse) == {WORD_W{1'b1}}));
  // R8: never both rails of a returned bit
  a_r8_no_double_rail: assert property (@(posedge clk) disable iff (!rstN)
    (instrTrue & instrFalse) == '0);
  // R5: enable pin opposes the strobe
  a_r5_enable_polarity: assert property (@(posedge clk) disable iff (!rstN)
    memEnN != ctl.fire);
endmodule

// File: rtl/fetch_mem_bridge.sv
module fetch_mem_bridge
  import fetch_mem_bridge_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addrTrue,
  input  logic [ADDR_W-1:0]   addrFalse,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memEnN,
  input  logic [BYTE_W-1:0]   memLo,
  input  logic [BYTE_W-1:0]   memHi,
  output logic [2*BYTE_W-1:0] instrTrue,
  output logic [2*BYTE_W-1:0] instrFalse
);
  bridgeCtl_t ctl;

  bridge_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .addrTrue (addrTrue),
    .addrFalse(addrFalse),
    .ctl      (ctl)
  );

  bridge_dpath #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .addrTrue  (addrTrue),
    .memAddr   (memAddr),
    .memEnN    (memEnN),
    .memLo     (memLo),
    .memHi     (memHi),
    .instrTrue (instrTrue),
    .instrFalse(instrFalse)
  );
endmodule

// File: tb/fetch_mem_bridge_test.sv
module fetch_mem_bridge_test;
  localparam int AW = 13;
  localparam int BW = 8;
  localparam int WW = 2 * BW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addrTrue = '0;
  logic [AW-1:0] addrFalse = '0;
  logic [AW-1:0] memAddr;
  logic          memEnN;
  logic [BW-1:0] memLo = '0;
  logic [BW-1:0] memHi = '0;
  logic [WW-1:0] instrTrue;
  logic [WW-1:0] instrFalse;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  fetch_mem_bridge #(.ADDR_W(AW), .BYTE_W(BW)) uut (
    .clk(clk), .rstN(rstN), .addrTrue(addrTrue), .addrFalse(addrFalse),
    .memAddr(memAddr), .memEnN(memEnN), .memLo(memLo), .memHi(memHi),
    .instrTrue(instrTrue), .instrFalse(instrFalse)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic drive(input logic [AW-1:0] t, input logic [AW-1:0] f);
    @(negedge clk);
    addrTrue  = t;
    addrFalse = f;
    @(negedge clk);
  endtask

  task automatic checkWord(input string req, input bit fired);
    logic [WW-1:0] w;
    w = {memHi, memLo};
    check(instrTrue == (fired ? w : '0), req, 32'(instrTrue), 32'(fired ? w : '0));
    check(instrFalse == (fired ? ~w : '0), req, 32'(instrFalse), 32'(fired ? ~w : '0));
    check((instrTrue & instrFalse) == '0, "R8", 32'(instrTrue & instrFalse), 0);
  endtask

  task automatic t_reset();
    memLo = 8'hA5; memHi = 8'h3C;
    #1;
    check(memEnN == 1'b1, "R5 reset", 32'(memEnN), 1);
    checkWord("R7 reset", 1'b0);
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic t_spacer_idle();
    drive('0, '0);
    check(memEnN == 1'b1, "R2 spacer", 32'(memEnN), 1);
    checkWord("R7 idle data", 1'b0);
  endtask

  task automatic t_partial_rise();
    logic [AW-1:0] v;
    logic [AW-1:0] m;
    v = 13'h0F0F;
    m = {1'b0, {(AW-1){1'b1}}};  // pair 12 left as spacer
    drive(v & m, ~v & m);
    check(memEnN == 1'b1, "R2 partial", 32'(memEnN), 1);
    checkWord("R7 partial", 1'b0);
    check(memAddr == (v & m), "R1 partial", 32'(memAddr), 32'(v & m));
  endtask

  task automatic t_complete_rise();
    logic [AW-1:0] v;
    v = 13'h0F0F;
    drive(v, ~v);
    check(memEnN == 1'b0, "R2 R5 complete", 32'(memEnN), 0);
    check(memAddr == v, "R1 complete", 32'(memAddr), 32'(v));
    checkWord("R6 word", 1'b1);
    memLo = 8'h01; memHi = 8'hFE;  // data change while fired
    #1;
    checkWord("R6 follow", 1'b1);
    check(instrTrue[15:8] == 8'hFE, "R6 high byte", 32'(instrTrue[15:8]), 32'hFE);
  endtask

  task automatic t_partial_return();
    drive(13'h0003, 13'h0000);
    check(memEnN == 1'b0, "R3 partial return", 32'(memEnN), 0);
    checkWord("R6 partial return", 1'b1);
  endtask

  task automatic t_illegal_high();
    drive(13'h0001, 13'h0001);
    check(memEnN == 1'b0, "R4 illegal while high", 32'(memEnN), 0);
  endtask

  task automatic t_full_return();
    drive('0, '0);
    check(memEnN == 1'b1, "R3 full return", 32'(memEnN), 1);
    checkWord("R7 after return", 1'b0);
    check(memAddr == '0, "R1 spacer", 32'(memAddr), 0);
  endtask

  task automatic t_illegal_low();
    logic [AW-1:0] v;
    v = 13'h1555;
    drive(v | 13'h0002, ~v);  // pair 1 both high, others valid
    check(memEnN == 1'b1, "R4 illegal while low", 32'(memEnN), 1);
    checkWord("R7 illegal low", 1'b0);
    check(memAddr == (v | 13'h0002), "R1 illegal", 32'(memAddr), 32'(v | 13'h0002));
    drive(v, ~v);
    check(memEnN == 1'b0, "R2 after illegal", 32'(memEnN), 0);
    memLo = 8'h5A; memHi = 8'hC3;
    #1;
    checkWord("R6 second word", 1'b1);
  endtask

  initial begin
    t_reset();
    t_spacer_idle();
    t_partial_rise();
    t_complete_rise();
    t_partial_return();
    t_illegal_high();
    t_full_return();
    t_illegal_low();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule